// File: doc/BRIEF.md
# Pad and Peripheral Signal Crossbar

This block sits between a bank of pads and the internal peripheral signals of a chip and decides, per signal, who talks to whom. Each peripheral input owns a small configuration word holding a pad selector, an inversion bit and a path bit. The path bit either routes the selected pad, or a forced constant, through the crossbar, or hands the peripheral its dedicated direct input instead. Each pad output owns a wider configuration word. That word picks which peripheral output drives the pad, or the pad's own bit of a software-owned output register. It also inverts the data on request and chooses, with its own inversion, where the pad's output enable comes from.

Software reaches the configuration words through a simple word-addressed write port with a registered read-back. The software output and enable registers live outside the block and arrive as plain input vectors. All routed results are registered, so each output is a flop fed by one wide multiplexer.

Top module: `pin_xbar`

## Requirements
- R1: While reset is held all of `peri_in`, `pad_out` and `pad_oe` are 0; after reset every input word reads back 0x3C and every output word reads back 0x080.
- R2: With input word bit 7 set and selector code c (bits 5:0) below N_PADS, `peri_in[i]` equals `pad_in[c]` sampled one clock earlier.
- R3: With bit 7 set, selector code 0x38 yields a constant 1; code 0x3C and every other code at or above N_PADS yield a constant 0.
- R4: Input word bit 6 inverts the crossbar value (pad or constant) before it reaches `peri_in[i]`.
- R5: With input word bit 7 clear, `peri_in[i]` equals `direct_in[i]` from one clock earlier, whatever the selector and bit 6 hold.
- R6: Output word code s (bits 7:0) below 128 drives `pad_out[p]` from `peri_out[s]`; any code of 128 or above drives it from `sw_out[p]`.
- R7: Output word bit 8 inverts the data driven onto `pad_out[p]`.
- R8: Output word bit 9 set takes the enable from `sw_oe[p]`; bit 9 clear takes it from `peri_oe[s]` when s is below 128 and from `sw_oe[p]` otherwise; bit 10 inverts the chosen enable.
- R9: Input word i sits at byte address 0x154 + 4*i and output word p at 0x554 + 4*p; a write stores bits 7:0 or 10:0 of the data, read-back returns the stored field zero-extended one clock after the address is presented, and any misaligned or unmapped address reads 0 and ignores writes.
- R10: A configuration write presented at clock edge k is reflected on the routed outputs from edge k+1 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Configuration write strobe |
| bus_addr | input | ADDR_W | Byte address of the configuration word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read-back data |
| pad_in | input | N_PADS | Values arriving from the pads |
| direct_in | input | N_IN | Dedicated direct inputs used when the crossbar is bypassed |
| peri_out | input | N_PO | Peripheral output data |
| peri_oe | input | N_PO | Peripheral output enables |
| sw_out | input | N_PADS | Software output register bits |
| sw_oe | input | N_PADS | Software output enable register bits |
| peri_in | output | N_IN | Routed peripheral inputs |
| pad_out | output | N_PADS | Routed pad output data |
| pad_oe | output | N_PADS | Routed pad output enables |

## Verification
Every routed output is one register away from its data inputs, so the bench changes data just after a falling edge and samples at the following falling edge, with exactly one rising edge in between. A configuration write needs one edge to land in the register array and one more to show at the outputs; the write task returns just after the storing edge, so the same single-edge wait covers both. Read-back is also one edge: the address is set after a falling edge and `bus_rdata` is read at the next falling edge.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;

  localparam logic [11:0] IN_WORD_BASE  = 12'h154;
  localparam logic [11:0] OUT_WORD_BASE = 12'h554;

  localparam logic [5:0] CODE_FORCE_HI = 6'h38;
  localparam logic [5:0] CODE_FORCE_LO = 6'h3C;

  // Input word: bit 7 path, bit 6 invert, bits 5:0 selector
  typedef struct packed {
    logic       route;
    logic       inv;
    logic [5:0] sel;
  } in_word_t;

  // Output word: bit 10 enable invert, bit 9 enable source, bit 8 invert, bits 7:0 source
  typedef struct packed {
    logic       oe_inv;
    logic       oe_sw;
    logic       inv;
    logic [7:0] src;
  } out_word_t;

  localparam int IN_WORD_W  = $bits(in_word_t);
  localparam int OUT_WORD_W = $bits(out_word_t);

  localparam in_word_t  IN_WORD_RST  = '{route: 1'b0, inv: 1'b0, sel: CODE_FORCE_LO};
  localparam out_word_t OUT_WORD_RST = '{oe_inv: 1'b0, oe_sw: 1'b0, inv: 1'b0, src: 8'd128};

endpackage

// File: rtl/pin_xbar_cfg.sv
module pin_xbar_cfg
  import pin_xbar_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_PADS = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output in_word_t  [N_IN-1:0]    in_cfg,
  output out_word_t [N_PADS-1:0]  out_cfg
);

  localparam int IN_IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int OUT_IDX_W = (N_PADS > 1) ? $clog2(N_PADS) : 1;
  localparam logic [ADDR_W-1:0] IN_BASE_A  = ADDR_W'(IN_WORD_BASE);
  localparam logic [ADDR_W-1:0] OUT_BASE_A = ADDR_W'(OUT_WORD_BASE);
  localparam logic [ADDR_W-1:0] IN_CNT_A   = ADDR_W'(N_IN);
  localparam logic [ADDR_W-1:0] OUT_CNT_A  = ADDR_W'(N_PADS);

  logic [ADDR_W-1:0]    in_off, out_off;
  logic                 in_hit, out_hit;
  logic [IN_IDX_W-1:0]  in_idx;
  logic [OUT_IDX_W-1:0] out_idx;
  logic                 unused_wdata;

  always_comb begin
    in_off  = addr - IN_BASE_A;
    out_off = addr - OUT_BASE_A;
    in_hit  = (addr >= IN_BASE_A)  && (addr[1:0] == 2'b00) && ((in_off  >> 2) < IN_CNT_A);
    out_hit = (addr >= OUT_BASE_A) && (addr[1:0] == 2'b00) && ((out_off >> 2) < OUT_CNT_A);
    in_idx  = in_off[IN_IDX_W+1:2];
    out_idx = out_off[OUT_IDX_W+1:2];
  end

  assign unused_wdata = ^wdata[DATA_W-1:OUT_WORD_W];

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in_word
    always_ff @(posedge clk) begin
      if (rst)
        in_cfg[gi] <= IN_WORD_RST;
      else if (we && in_hit && (in_idx == IN_IDX_W'(gi)))
        in_cfg[gi] <= in_word_t'(wdata[IN_WORD_W-1:0]);
    end
  end

  for (genvar gp = 0; gp < N_PADS; gp++) begin : g_out_word
    always_ff @(posedge clk) begin
      if (rst)
        out_cfg[gp] <= OUT_WORD_RST;
      else if (we && out_hit && (out_idx == OUT_IDX_W'(gp)))
        out_cfg[gp] <= out_word_t'(wdata[OUT_WORD_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (in_hit)
      rdata <= DATA_W'(in_cfg[in_idx]);
    else if (out_hit)
      rdata <= DATA_W'(out_cfg[out_idx]);
    else
      rdata <= '0;
  end

endmodule

// File: rtl/pin_xbar_in_route.sv
module pin_xbar_in_route
  import pin_xbar_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_PADS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  in_word_t [N_IN-1:0]  in_cfg,
  input  logic [N_PADS-1:0]    pad_in,
  input  logic [N_IN-1:0]      direct_in,
  output logic [N_IN-1:0]      peri_in
);

  // Every 6-bit code maps into this span; codes at or above N_PADS read 0
  localparam int CODE_SPAN = 64;

  logic [CODE_SPAN-1:0] pad_span;
  assign pad_span = CODE_SPAN'(pad_in);

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    logic xbar_val, next_val;

    always_comb begin
      xbar_val = (in_cfg[gi].sel == CODE_FORCE_HI) ? 1'b1 : pad_span[in_cfg[gi].sel];
      next_val = in_cfg[gi].route ? (xbar_val ^ in_cfg[gi].inv) : direct_in[gi];
    end

    always_ff @(posedge clk) begin
      if (rst) peri_in[gi] <= 1'b0;
      else     peri_in[gi] <= next_val;
    end
  end

endmodule

// File: rtl/pin_xbar_out_route.sv
module pin_xbar_out_route
  import pin_xbar_pkg::*;
#(
  parameter int N_PADS = 32,
  parameter int N_PO   = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  out_word_t [N_PADS-1:0] out_cfg,
  input  logic [N_PO-1:0]        peri_out,
  input  logic [N_PO-1:0]        peri_oe,
  input  logic [N_PADS-1:0]      sw_out,
  input  logic [N_PADS-1:0]      sw_oe,
  output logic [N_PADS-1:0]      pad_out,
  output logic [N_PADS-1:0]      pad_oe
);

  // Codes below 128 index this span; codes past N_PO read 0
  localparam int PERI_SPAN = 128;

  logic [PERI_SPAN-1:0] po_span, oe_span;
  assign po_span = PERI_SPAN'(peri_out);
  assign oe_span = PERI_SPAN'(peri_oe);

  for (genvar gp = 0; gp < N_PADS; gp++) begin : g_pad
    logic use_sw, d_raw, e_raw, d_next, e_next;

    always_comb begin
      use_sw = out_cfg[gp].src[7];
      d_raw  = use_sw ? sw_out[gp] : po_span[out_cfg[gp].src[6:0]];
      e_raw  = (use_sw || out_cfg[gp].oe_sw) ? sw_oe[gp] : oe_span[out_cfg[gp].src[6:0]];
      d_next = d_raw ^ out_cfg[gp].inv;
      e_next = e_raw ^ out_cfg[gp].oe_inv;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[gp] <= 1'b0;
        pad_oe[gp]  <= 1'b0;
      end else begin
        pad_out[gp] <= d_next;
        pad_oe[gp]  <= e_next;
      end
    end
  end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int N_PADS = 32,
  parameter int N_IN   = 16,
  parameter int N_PO   = 128,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PADS-1:0] pad_in,
  input  logic [N_IN-1:0]   direct_in,
  input  logic [N_PO-1:0]   peri_out,
  input  logic [N_PO-1:0]   peri_oe,
  input  logic [N_PADS-1:0] sw_out,
  input  logic [N_PADS-1:0] sw_oe,
  output logic [N_IN-1:0]   peri_in,
  output logic [N_PADS-1:0] pad_out,
  output logic [N_PADS-1:0] pad_oe
);

  in_word_t  [N_IN-1:0]   in_cfg_q;
  out_word_t [N_PADS-1:0] out_cfg_q;

  pin_xbar_cfg #(
    .N_IN(N_IN), .N_PADS(N_PADS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .in_cfg(in_cfg_q), .out_cfg(out_cfg_q)
  );

  pin_xbar_in_route #(
    .N_IN(N_IN), .N_PADS(N_PADS)
  ) u_in (
    .clk(clk), .rst(rst), .in_cfg(in_cfg_q), .pad_in(pad_in),
    .direct_in(direct_in), .peri_in(peri_in)
  );

  pin_xbar_out_route #(
    .N_PADS(N_PADS), .N_PO(N_PO)
  ) u_out (
    .clk(clk), .rst(rst), .out_cfg(out_cfg_q), .peri_out(peri_out),
    .peri_oe(peri_oe), .sw_out(sw_out), .sw_oe(sw_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int N_PADS = 32,
  parameter int N_IN   = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input in_word_t  [N_IN-1:0]   in_cfg,
  input out_word_t [N_PADS-1:0] out_cfg,
  input logic [N_IN-1:0]        direct_in,
  input logic [N_PADS-1:0]      sw_out,
  input logic [N_PADS-1:0]      sw_oe,
  input logic [N_IN-1:0]        peri_in,
  input logic [N_PADS-1:0]      pad_out,
  input logic [N_PADS-1:0]      pad_oe,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_rdata
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (peri_in == '0 && pad_out == '0 && pad_oe == '0));

  p_low_addr_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_addr < ADDR_W'(IN_WORD_BASE)) |-> bus_rdata == '0);

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in_chk
    p_bypass_direct_r5: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && !in_cfg[gi].route) |-> peri_in[gi] == $past(direct_in[gi]));

    p_force_high_r3: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && in_cfg[gi].route && in_cfg[gi].sel == CODE_FORCE_HI)
        |-> peri_in[gi] == !$past(in_cfg[gi].inv));

    p_force_low_r3: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && in_cfg[gi].route && in_cfg[gi].sel == CODE_FORCE_LO)
        |-> peri_in[gi] == $past(in_cfg[gi].inv));
  end

  for (genvar gp = 0; gp < N_PADS; gp++) begin : g_pad_chk
    p_sw_source_r8: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && out_cfg[gp].src[7] && out_cfg[gp].oe_sw)
        |-> (pad_out[gp] == $past(sw_out[gp] ^ out_cfg[gp].inv)
             && pad_oe[gp] == $past(sw_oe[gp] ^ out_cfg[gp].oe_inv)));
  end

endmodule

bind pin_xbar pin_xbar_chk #(
  .N_PADS(N_PADS), .N_IN(N_IN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .in_cfg(in_cfg_q), .out_cfg(out_cfg_q),
  .direct_in(direct_in), .sw_out(sw_out), .sw_oe(sw_oe),
  .peri_in(peri_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/pin_xbar_tb.sv
module pin_xbar_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_PADS = 32;
  localparam int N_IN   = 16;
  localparam int N_PO   = 128;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [N_PADS-1:0] pad_in = '0;
  logic [N_IN-1:0]   direct_in = '0;
  logic [N_PO-1:0]   peri_out = '0;
  logic [N_PO-1:0]   peri_oe = '0;
  logic [N_PADS-1:0] sw_out = '0;
  logic [N_PADS-1:0] sw_oe = '0;
  logic [N_IN-1:0]   peri_in;
  logic [N_PADS-1:0] pad_out;
  logic [N_PADS-1:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  sh_in  [N_IN];
  logic [10:0] sh_out [N_PADS];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_xbar #(
    .N_PADS(N_PADS), .N_IN(N_IN), .N_PO(N_PO), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .direct_in(direct_in), .peri_out(peri_out), .peri_oe(peri_oe),
    .sw_out(sw_out), .sw_oe(sw_oe), .peri_in(peri_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Map from R9: inputs at 0x154+4i, outputs at 0x554+4p, aligned only
  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    int off;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a[1:0] == 2'b00) begin
      if (int'(a) >= 'h154 && (int'(a) - 'h154) / 4 < N_IN) begin
        off = (int'(a) - 'h154) / 4;
        sh_in[off] = d[7:0];
      end else if (int'(a) >= 'h554 && (int'(a) - 'h554) / 4 < N_PADS) begin
        off = (int'(a) - 'h554) / 4;
        sh_out[off] = d[10:0];
      end
    end
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic exp_in(int i);
    logic [7:0] c = sh_in[i];
    logic v;
    if (!c[7]) return direct_in[i];
    if (c[5:0] == 6'h38) v = 1'b1;
    else if (int'(c[5:0]) < N_PADS) v = pad_in[c[4:0]];
    else v = 1'b0;
    return v ^ c[6];
  endfunction

  function automatic logic exp_dat(int p);
    logic [10:0] c = sh_out[p];
    logic d = c[7] ? sw_out[p] : peri_out[c[6:0]];
    return d ^ c[8];
  endfunction

  function automatic logic exp_oe(int p);
    logic [10:0] c = sh_out[p];
    logic e = (c[9] || c[7]) ? sw_oe[p] : peri_oe[c[6:0]];
    return e ^ c[10];
  endfunction

  task automatic check_outputs(string tag);
    logic [N_IN-1:0]   ei;
    logic [N_PADS-1:0] ed, ee;
    for (int i = 0; i < N_IN; i++) ei[i] = exp_in(i);
    for (int p = 0; p < N_PADS; p++) begin
      ed[p] = exp_dat(p);
      ee[p] = exp_oe(p);
    end
    check({tag, " peri_in"}, 128'(peri_in), 128'(ei));
    check({tag, " pad_out"}, 128'(pad_out), 128'(ed));
    check({tag, " pad_oe"},  128'(pad_oe),  128'(ee));
  endtask

  task automatic new_data();
    pad_in    = $urandom;
    direct_in = N_IN'($urandom);
    peri_out  = {$urandom, $urandom, $urandom, $urandom};
    peri_oe   = {$urandom, $urandom, $urandom, $urandom};
    sw_out    = $urandom;
    sw_oe     = $urandom;
  endtask

  // Drive fresh data, let one rising edge register it, sample at the falling edge
  task automatic step(string tag);
    new_data();
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rv;
    void'($urandom(32'd1234));
    for (int i = 0; i < N_IN; i++) sh_in[i] = 8'h3C;
    for (int p = 0; p < N_PADS; p++) sh_out[p] = 11'h080;

    // R1: outputs held low under reset despite active inputs
    new_data();
    repeat (3) @(negedge clk);
    check("R1 reset peri_in", 128'(peri_in), 128'(0));
    check("R1 reset pad_out", 128'(pad_out), 128'(0));
    check("R1 reset pad_oe",  128'(pad_oe),  128'(0));
    rst = 1'b0;

    // R1: reset values of the configuration words
    rd(12'h154, rv); check("R1 in word reset", 128'(rv), 128'(32'h3C));
    rd(12'h5D0, rv); check("R1 out word reset", 128'(rv), 128'(32'h080));

    // R5: bypass path is the reset default; R6 software source default
    step("R5 R6 default");

    // R3: forced constants and unlisted codes
    wr(12'h154, 32'h0000_00B8); step("R3 force high");
    wr(12'h154, 32'h0000_00BC); step("R3 force low");
    wr(12'h154, 32'h0000_00A3); step("R3 unlisted code 35");
    wr(12'h154, 32'h0000_00B0); step("R3 code 48 beyond pads");
    // R4: inversion of forced low and of a pad
    wr(12'h154, 32'h0000_00FC); step("R4 inverted force low");
    wr(12'h158, 32'h0000_00C7); step("R4 inverted pad 7");
    // R2: pad routing, both pad edges of the range
    wr(12'h15C, 32'h0000_0080); step("R2 pad 0");
    wr(12'h160, 32'h0000_009F); step("R2 pad 31");
    // R5: bypass ignores selector and invert bit
    wr(12'h164, 32'h0000_0078); step("R5 bypass with inv");

    // R6/R7/R8 on pad 3 (word 0x560)
    wr(12'h560, 32'h0000_0005); step("R6 peri 5");
    wr(12'h560, 32'h0000_007F); step("R6 peri 127");
    wr(12'h560, 32'h0000_00C8); step("R6 code 200 software");
    wr(12'h560, 32'h0000_0105); step("R7 invert data");
    wr(12'h560, 32'h0000_0205); step("R8 software enable");
    wr(12'h560, 32'h0000_0405); step("R8 invert peri enable");
    wr(12'h560, 32'h0000_0785); step("R8 sw source both inverts");

    // R10: a write shows at the outputs one edge after it is stored
    wr(12'h168, 32'h0000_00B8);
    @(negedge clk);
    check("R10 write latency", 128'(peri_in[5]), 128'(1'b1));

    // R9: masking, read-back, unmapped and misaligned addresses
    wr(12'h190, 32'hFFFF_FFFF);
    rd(12'h190, rv); check("R9 in word mask", 128'(rv), 128'(32'h0000_00FF));
    wr(12'h554, 32'hFFFF_FFFF);
    rd(12'h554, rv); check("R9 out word mask", 128'(rv), 128'(32'h0000_07FF));
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, rv); check("R9 unmapped read", 128'(rv), 128'(0));
    rd(12'h194, rv); check("R9 gap after inputs", 128'(rv), 128'(0));
    wr(12'h156, 32'h0000_00B8);
    rd(12'h154, rv); check("R9 misaligned write ignored", 128'(rv), 128'(32'hFC));
    step("R9 outputs after ignored writes");

    // Random configurations mixed with random data
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(1, 0) == 1) begin
        int i = $urandom_range(N_IN - 1, 0);
        wr(ADDR_W'(32'h154 + 4 * i), $urandom);
      end else begin
        int p = $urandom_range(N_PADS - 1, 0);
        wr(ADDR_W'(32'h554 + 4 * p), $urandom);
      end
      step("R2 R4 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule